// File: doc/BRIEF.md
# Row-Structured Packet Buffer with Auto-Advancing Read Port

This block holds received data packets in a byte-wide on-chip RAM and hands them to a host one byte at a time. Each kept packet fills one fixed-size row. A row starts with two information bytes (line number, then field and data type). For teletext these are followed by two address bytes and forty payload bytes, and every other format uses the same layout. The first row-sized region of the RAM is set aside for control information and never receives packet data. The rows after it form a ring.

The host reads from a single 8-bit port. Each read strobe returns the next byte in the order the bytes were received, and the read position moves on to the next row by itself once the last byte of a row has been read. Three pointer commands let the host reposition the read side:
- flush: back to the first packet row, discarding everything stored;
- rewind: back to the first byte of the row being read;
- next: skip the rest of the current row.

An upstream filter decides whether a packet is kept, and the block takes that decision as an input with the packet's first byte. Packets that arrive while every row holds unread data are dropped and recorded in a sticky flag.

Top module: `pkt_row_buffer`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, `rd_data` is 0, `rd_ack` is 0, `rd_empty` is 0 and `ovf` is 0. No row is pending, and both the write and read positions are at byte 0 of the first packet row.
- R2: A row opens when `in_valid`, `in_first` and `in_keep` are all 1, and that byte is byte 0 of the row. The next ROW_BYTES-1 cycles with `in_valid`=1 and `in_first`=0 fill bytes 1 to ROW_BYTES-1. The row becomes readable only after byte ROW_BYTES-1 has been stored, and all rows lie above the reserved region of the first ROW_BYTES RAM addresses.
- R3: A byte with `in_valid`=1, `in_first`=1 and `in_keep`=0 abandons any partly filled row, so none of its bytes can be read. Bytes with `in_valid`=1 and `in_first`=0 while no row is open are ignored.
- R4: A read strobe (`rd_stb`=1 with no command) while at least one complete row is pending drives `rd_data` to the next unread byte and sets `rd_ack`=1 in the following cycle. Bytes come out in the order they were written.
- R5: After byte ROW_BYTES-1 of a row has been read, the next read returns byte 0 of the following row. Both the write and the read row index wrap from the last row (NUM_ROWS = floor((MEM_BYTES-ROW_BYTES)/ROW_BYTES), 45 by default) to the first.
- R6: A read strobe with no complete row pending leaves `rd_data` unchanged, gives `rd_ack`=0 and sets `rd_empty`=1. `rd_empty` stays set until a successful read or a flush.
- R7: `cmd_flush` empties the buffer, aborts any open row and returns both positions to byte 0 of the first packet row; input bytes in the same cycle are ignored. The commands rank flush over rewind over next, and a `rd_stb` in the same cycle as any command is ignored.
- R8: `cmd_rewind` makes the next read return byte 0 of the row currently being read.
- R9: `cmd_next` with a complete row pending releases the current row, and the next read returns byte 0 of the following row. With no row pending it has no effect.
- R10: A kept first byte that arrives while NUM_ROWS complete rows are unread (the row being read counts) is dropped together with the rest of its packet. It sets `ovf`, which stays 1 until reset; a flush does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (hold at least two cycles) |
| in_valid | input | 1 | Incoming byte valid |
| in_first | input | 1 | Incoming byte is byte 0 of a packet |
| in_keep | input | 1 | Filter decision for the packet, sampled with its first byte |
| in_byte | input | 8 | Incoming byte |
| rd_stb | input | 1 | Host read strobe |
| cmd_flush | input | 1 | Return to first packet row and discard contents |
| cmd_rewind | input | 1 | Return to byte 0 of the current row |
| cmd_next | input | 1 | Skip to byte 0 of the next row |
| rd_data | output | 8 | Byte returned by the last successful read |
| rd_ack | output | 1 | High for one cycle when `rd_data` carries a new byte |
| rd_empty | output | 1 | Last read found no complete row |
| ovf | output | 1 | Sticky: a packet was dropped because all rows were full |

## Verification
The bench uses the default values: a 2048-byte RAM with 44-byte rows, which gives 45 packet rows. It can therefore fill every row, push one packet more to trigger the overflow, and read the whole ring so that both row indices wrap. Random runs of several thousand cycles write, read and issue commands in the same cycle. This reaches the cases where a row completes and a row is released on the same edge, and where a command collides with a strobe or with an incoming byte.

// File: rtl/pkt_buf_pkg.sv
package pkt_buf_pkg;

  // Decoded pointer command after priority resolution.
  typedef enum logic [1:0] {
    PC_NONE   = 2'd0,
    PC_FLUSH  = 2'd1,
    PC_REWIND = 2'd2,
    PC_NEXT   = 2'd3
  } ptr_cmd_e;

  // Packet rows that fit after the reserved control region.
  function automatic int row_count(input int mem_bytes, input int row_bytes);
    return (mem_bytes - row_bytes) / row_bytes;
  endfunction

endpackage

// File: rtl/pkt_buf_mem.sv
module pkt_buf_mem #(
  parameter int DEPTH   = 2048,
  parameter int ADDR_W  = 11,
  parameter int RSV     = 44
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  logic [7:0] ram [DEPTH];

  // Simple dual-port RAM, write port.
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  // Read port with enabled, resettable output register.
  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (re) rdata <= ram[raddr];
  end

  AST_RESERVED_ROW: assert property (@(posedge clk) disable iff (rst)
    we |-> (int'(waddr) >= RSV)); // R2

  AST_READ_ABOVE_RSV: assert property (@(posedge clk) disable iff (rst)
    re |-> (int'(raddr) >= RSV)); // R2

endmodule

// File: rtl/pkt_buf_occ.sv
module pkt_buf_occ #(
  parameter int NUM_ROWS = 45,
  parameter int CNT_W    = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic commit,
  input  logic release_row,
  output logic has_row,
  output logic full
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt <= '0;
    end else begin
      case ({commit, release_row})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign has_row = (cnt != '0);
  assign full    = (cnt == CNT_W'(NUM_ROWS));

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(cnt) <= NUM_ROWS); // R10

  AST_NO_RELEASE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    release_row |-> (cnt != '0)); // R9

  AST_NO_COMMIT_FULL: assert property (@(posedge clk) disable iff (rst)
    (commit && !release_row && !flush) |-> (int'(cnt) < NUM_ROWS)); // R10

endmodule

// File: rtl/pkt_buf_wr_ctrl.sv
module pkt_buf_wr_ctrl #(
  parameter int ROW_BYTES = 44,
  parameter int NUM_ROWS  = 45,
  parameter int ROW_W     = 6,
  parameter int OFF_W     = 6,
  parameter int ADDR_W    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              full,
  input  logic              in_valid,
  input  logic              in_first,
  input  logic              in_keep,
  input  logic [7:0]        in_byte,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [7:0]        wdata,
  output logic              commit,
  output logic              drop
);

  logic [ROW_W-1:0] wr_row;
  logic [OFF_W-1:0] wr_off;
  logic             active;

  logic             start_req;
  logic             start_ok;
  logic             cont;
  logic [OFF_W-1:0] off_now;

  always_comb begin
    start_req = in_valid && in_first && in_keep && !flush;
    start_ok  = start_req && !full;
    drop      = start_req && full;
    cont      = in_valid && !in_first && active && !flush;
    we        = start_ok || cont;
    off_now   = start_ok ? '0 : wr_off;
    waddr     = ADDR_W'((32'(wr_row) + 32'd1) * 32'(ROW_BYTES) + 32'(off_now));
    wdata     = in_byte;
    commit    = cont && (wr_off == OFF_W'(ROW_BYTES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_row <= '0;
      wr_off <= '0;
      active <= 1'b0;
    end else if (in_valid && in_first) begin
      active <= start_ok;
      wr_off <= start_ok ? OFF_W'(1) : '0;
    end else if (cont) begin
      if (commit) begin
        active <= 1'b0;
        wr_off <= '0;
        wr_row <= (wr_row == ROW_W'(NUM_ROWS - 1)) ? '0 : wr_row + 1'b1;
      end else begin
        wr_off <= wr_off + 1'b1;
      end
    end
  end

  AST_WR_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    active |-> ((wr_off != '0) && (int'(wr_off) < ROW_BYTES))); // R2

  AST_WR_ROW_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(wr_row) < NUM_ROWS); // R5

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!active && !(in_valid && in_first)) |-> !we); // R3

endmodule

// File: rtl/pkt_buf_rd_ctrl.sv
module pkt_buf_rd_ctrl
  import pkt_buf_pkg::*;
#(
  parameter int ROW_BYTES = 44,
  parameter int NUM_ROWS  = 45,
  parameter int ROW_W     = 6,
  parameter int OFF_W     = 6,
  parameter int ADDR_W    = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  ptr_cmd_e          cmd,
  input  logic              rd_stb,
  input  logic              has_row,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic              release_row,
  output logic              rd_ack,
  output logic              rd_empty
);

  logic [ROW_W-1:0] rd_row;
  logic [OFF_W-1:0] rd_off;
  logic             go;
  logic             last_byte;
  logic [ROW_W-1:0] row_inc;

  always_comb begin
    go          = rd_stb && (cmd == PC_NONE);
    re          = go && has_row;
    raddr       = ADDR_W'((32'(rd_row) + 32'd1) * 32'(ROW_BYTES) + 32'(rd_off));
    last_byte   = (rd_off == OFF_W'(ROW_BYTES - 1));
    row_inc     = (rd_row == ROW_W'(NUM_ROWS - 1)) ? '0 : rd_row + 1'b1;
    release_row = (re && last_byte) || ((cmd == PC_NEXT) && has_row);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_row   <= '0;
      rd_off   <= '0;
      rd_ack   <= 1'b0;
      rd_empty <= 1'b0;
    end else begin
      rd_ack <= re;
      case (cmd)
        PC_FLUSH: begin
          rd_row   <= '0;
          rd_off   <= '0;
          rd_empty <= 1'b0;
        end
        PC_REWIND: rd_off <= '0;
        PC_NEXT: begin
          if (has_row) begin
            rd_row <= row_inc;
            rd_off <= '0;
          end
        end
        default: begin
          if (re) begin
            rd_empty <= 1'b0;
            if (last_byte) begin
              rd_off <= '0;
              rd_row <= row_inc;
            end else begin
              rd_off <= rd_off + 1'b1;
            end
          end else if (go) begin
            rd_empty <= 1'b1;
          end
        end
      endcase
    end
  end

  AST_RD_OFF_RANGE: assert property (@(posedge clk) disable iff (rst)
    int'(rd_off) < ROW_BYTES); // R5

  AST_CMD_BLOCKS_READ: assert property (@(posedge clk) disable iff (rst)
    (cmd != PC_NONE) |=> !rd_ack); // R7

  AST_REWIND_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cmd == PC_REWIND) |=> (rd_off == '0)); // R8

endmodule

// File: rtl/pkt_row_buffer.sv
module pkt_row_buffer
  import pkt_buf_pkg::*;
#(
  parameter int MEM_BYTES = 2048,
  parameter int ROW_BYTES = 44
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  input  logic       in_first,
  input  logic       in_keep,
  input  logic [7:0] in_byte,
  input  logic       rd_stb,
  input  logic       cmd_flush,
  input  logic       cmd_rewind,
  input  logic       cmd_next,
  output logic [7:0] rd_data,
  output logic       rd_ack,
  output logic       rd_empty,
  output logic       ovf
);

  localparam int NUM_ROWS = row_count(MEM_BYTES, ROW_BYTES);
  localparam int ROW_W    = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int OFF_W    = (ROW_BYTES > 1) ? $clog2(ROW_BYTES) : 1;
  localparam int CNT_W    = $clog2(NUM_ROWS + 1);
  localparam int ADDR_W   = $clog2(MEM_BYTES);

  ptr_cmd_e          cmd;
  logic              flush;
  logic              has_row;
  logic              full;
  logic              we;
  logic [ADDR_W-1:0] waddr;
  logic [7:0]        wdata;
  logic              commit;
  logic              drop;
  logic              re;
  logic [ADDR_W-1:0] raddr;
  logic              release_row;

  // Command priority: flush, then rewind, then next.
  always_comb begin
    if (cmd_flush)       cmd = PC_FLUSH;
    else if (cmd_rewind) cmd = PC_REWIND;
    else if (cmd_next)   cmd = PC_NEXT;
    else                 cmd = PC_NONE;
    flush = (cmd == PC_FLUSH);
  end

  pkt_buf_wr_ctrl #(
    .ROW_BYTES(ROW_BYTES), .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W),
    .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) wr_i (
    .clk(clk), .rst(rst), .flush(flush), .full(full),
    .in_valid(in_valid), .in_first(in_first), .in_keep(in_keep),
    .in_byte(in_byte), .we(we), .waddr(waddr), .wdata(wdata),
    .commit(commit), .drop(drop)
  );

  pkt_buf_rd_ctrl #(
    .ROW_BYTES(ROW_BYTES), .NUM_ROWS(NUM_ROWS), .ROW_W(ROW_W),
    .OFF_W(OFF_W), .ADDR_W(ADDR_W)
  ) rd_i (
    .clk(clk), .rst(rst), .cmd(cmd), .rd_stb(rd_stb), .has_row(has_row),
    .re(re), .raddr(raddr), .release_row(release_row),
    .rd_ack(rd_ack), .rd_empty(rd_empty)
  );

  pkt_buf_occ #(
    .NUM_ROWS(NUM_ROWS), .CNT_W(CNT_W)
  ) occ_i (
    .clk(clk), .rst(rst), .flush(flush), .commit(commit),
    .release_row(release_row), .has_row(has_row), .full(full)
  );

  pkt_buf_mem #(
    .DEPTH(MEM_BYTES), .ADDR_W(ADDR_W), .RSV(ROW_BYTES)
  ) mem_i (
    .clk(clk), .rst(rst), .we(we), .waddr(waddr), .wdata(wdata),
    .re(re), .raddr(raddr), .rdata(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst)       ovf <= 1'b0;
    else if (drop) ovf <= 1'b1;
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R10

  AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (cmd == PC_NONE) && !has_row) |=>
      (rd_empty && !rd_ack && $stable(rd_data))); // R6

  AST_READ_ACK: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && (cmd == PC_NONE) && has_row) |=> rd_ack); // R4

endmodule

// File: tb/pkt_row_buffer_tb_top.sv
`timescale 1ns/1ps
module pkt_row_buffer_tb_top;

  localparam int MEMB = 2048;
  localparam int RB   = 44;
  localparam int NR   = (MEMB - RB) / RB;
  localparam real TCK = 8.0;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 0, in_first = 0, in_keep = 0;
  logic [7:0] in_byte = '0;
  logic       rd_stb = 0, cmd_flush = 0, cmd_rewind = 0, cmd_next = 0;
  logic [7:0] rd_data;
  logic       rd_ack, rd_empty, ovf;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  // Reference model state
  logic [7:0] mm [NR*RB];
  int  m_wr_row, m_wr_off, m_rd_row, m_rd_off, m_cnt;
  bit  m_act, m_ovf, m_empty, m_ack;
  logic [7:0] m_last;
  int  gen_off;

  always #(TCK/2) clk = ~clk;

  pkt_row_buffer #(.MEM_BYTES(MEMB), .ROW_BYTES(RB)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_keep(in_keep), .in_byte(in_byte), .rd_stb(rd_stb),
    .cmd_flush(cmd_flush), .cmd_rewind(cmd_rewind), .cmd_next(cmd_next),
    .rd_data(rd_data), .rd_ack(rd_ack), .rd_empty(rd_empty), .ovf(ovf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int next_row(input int r);
    return (r == NR - 1) ? 0 : r + 1;
  endfunction

  task automatic model_reset();
    m_wr_row = 0; m_wr_off = 0; m_rd_row = 0; m_rd_off = 0; m_cnt = 0;
    m_act = 0; m_ovf = 0; m_empty = 0; m_ack = 0; m_last = '0;
  endtask

  // Model one clock edge; all decisions use the pre-edge row count.
  task automatic model_step(input bit v, f, k, input logic [7:0] b,
                            input bit stb, fl, rw, nx, output string auto_tag);
    int cnt0 = m_cnt;
    int dc = 0;
    auto_tag = "R2";
    m_ack = 0;
    if (fl) begin
      m_wr_row = 0; m_wr_off = 0; m_rd_row = 0; m_rd_off = 0;
      m_cnt = 0; m_act = 0; m_empty = 0;
      auto_tag = "R7";
      return;
    end
    if (v && f) begin
      if (k) begin
        if (cnt0 == NR) begin m_ovf = 1; m_act = 0; auto_tag = "R10"; end
        else begin mm[m_wr_row*RB] = b; m_wr_off = 1; m_act = 1; end
      end else begin
        m_act = 0; auto_tag = "R3";
      end
    end else if (v && m_act) begin
      mm[m_wr_row*RB + m_wr_off] = b;
      if (m_wr_off == RB - 1) begin
        m_act = 0; m_wr_off = 0; m_wr_row = next_row(m_wr_row); dc++;
      end else m_wr_off++;
    end
    if (rw) begin
      m_rd_off = 0; auto_tag = "R8";
    end else if (nx) begin
      auto_tag = "R9";
      if (cnt0 > 0) begin m_rd_row = next_row(m_rd_row); m_rd_off = 0; dc--; end
    end else if (stb) begin
      if (cnt0 > 0) begin
        m_last = mm[m_rd_row*RB + m_rd_off]; m_ack = 1; m_empty = 0;
        auto_tag = "R4";
        if (m_rd_off == RB - 1) begin
          m_rd_off = 0; m_rd_row = next_row(m_rd_row); dc--; auto_tag = "R5";
        end else m_rd_off++;
      end else begin
        m_empty = 1; auto_tag = "R6";
      end
    end
    m_cnt = cnt0 + dc;
  endtask

  // One cycle: drive at negedge, check at the next negedge.
  task automatic cyc(input bit v, f, k, input logic [7:0] b,
                     input bit stb, fl, rw, nx, input string tag);
    string at;
    string t;
    in_valid = v; in_first = f; in_keep = k; in_byte = b;
    rd_stb = stb; cmd_flush = fl; cmd_rewind = rw; cmd_next = nx;
    model_step(v, f, k, b, stb, fl, rw, nx, at);
    t = (tag == "") ? at : tag;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0; in_first = 0; in_keep = 0; rd_stb = 0;
    cmd_flush = 0; cmd_rewind = 0; cmd_next = 0;
    check(rd_ack == m_ack, t, "rd_ack", rd_ack, m_ack);
    check(rd_data == m_last, t, "rd_data", rd_data, m_last);
    check(rd_empty == m_empty, t, "rd_empty", rd_empty, m_empty);
    check(ovf == m_ovf, t, "ovf", ovf, m_ovf);
  endtask

  task automatic wr(input bit f, k, input logic [7:0] b, input string tag);
    cyc(1, f, k, b, 0, 0, 0, 0, tag);
  endtask

  task automatic rd(input string tag);
    cyc(0, 0, 0, 8'h00, 1, 0, 0, 0, tag);
  endtask

  // Header byte 0 = line number, byte 1 = field/type, then payload.
  task automatic put_row(input bit keep, input int nbytes, input int line,
                         input string tag);
    for (int i = 0; i < nbytes; i++) begin
      logic [7:0] b;
      if (i == 0) b = 8'(line);
      else if (i == 1) b = 8'($urandom_range(0, 15));
      else b = 8'($urandom);
      wr(i == 0, keep, b, tag);
    end
  endtask

  task automatic rd_n(input int n, input string tag);
    for (int i = 0; i < n; i++) rd(tag);
  endtask

  initial begin
    #(TCK * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired: actual 1 expected 0");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    gen_off = 0;
    rst = 1;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(rd_data == 8'h00 && !rd_ack && !rd_empty && !ovf, "R1",
          "reset outputs", {rd_data, rd_ack, rd_empty, ovf}, 0);
    rst = 0;
    @(negedge clk);
    check(rd_data == 8'h00 && !rd_ack && !rd_empty && !ovf, "R1",
          "post-reset outputs", {rd_data, rd_ack, rd_empty, ovf}, 0);

    // R6: read from empty buffer
    rd("R6");
    // R2: partial row is not readable
    put_row(1, 20, 5, "R2");
    rd("R2");
    // R3: abort by rejected first byte, stray bytes ignored
    wr(1, 0, 8'hAA, "R3");
    for (int i = 0; i < 10; i++) wr(0, 0, 8'(8'h50 + i), "R3");
    rd("R3");
    put_row(1, RB, 7, "R3");
    rd_n(RB, "R3");
    rd("R6");

    // R8 / R9: rewind and next
    put_row(1, RB, 8, "R2");
    put_row(1, RB, 9, "R2");
    put_row(1, RB, 10, "R2");
    rd_n(10, "R4");
    cyc(0, 0, 0, 8'h0, 0, 0, 1, 0, "R8");
    rd_n(5, "R8");
    cyc(0, 0, 0, 8'h0, 0, 0, 0, 1, "R9");
    rd("R9");
    // R7: priority rewind over next, strobe ignored
    cyc(0, 0, 0, 8'h0, 1, 0, 1, 1, "R7");
    rd("R7");
    rd_n(RB - 1, "R5");
    // R7: flush with strobe and a kept first byte in same cycle
    cyc(1, 1, 1, 8'h33, 1, 1, 0, 0, "R7");
    rd("R7");
    // R9: next on empty buffer has no effect
    cyc(0, 0, 0, 8'h0, 0, 0, 0, 1, "R9");
    rd("R9");

    // R10 / R5: fill all rows, overflow, drain with wrap
    for (int r = 0; r < NR; r++) put_row(1, RB, r + 2, "R5");
    put_row(1, RB, 99, "R10");
    rd("R10");
    rd_n(NR * RB - 1, "R5");
    rd("R6");
    put_row(1, RB, 3, "R5");
    rd_n(RB, "R5");
    cyc(0, 0, 0, 8'h0, 0, 1, 0, 0, "R10");

    // Random mix with concurrent write/read/commands
    for (int n = 0; n < 20000; n++) begin
      bit v, f, k, stb, fl, rw, nx;
      logic [7:0] b;
      int p;
      v = ($urandom_range(0, 99) < 55);
      f = 0; k = 0;
      b = 8'($urandom);
      if (v) begin
        if (gen_off == 0 || $urandom_range(0, 199) == 0) begin
          f = 1; k = ($urandom_range(0, 99) < 85); gen_off = 1;
        end else begin
          gen_off = (gen_off == RB - 1) ? 0 : gen_off + 1;
        end
      end
      stb = ($urandom_range(0, 99) < 45);
      p = $urandom_range(0, 999);
      fl = (p < 3);
      rw = (p >= 3 && p < 25);
      nx = (p >= 25 && p < 45);
      cyc(v, f, k, b, stb, fl, rw, nx, "");
    end

    report();
  end

endmodule